// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a feedback input stream by a programmable ratio N = B·P + A and a reference stream by a separate ratio R. The ratio N is not held in one long loadable counter. A small dual-modulus prescaler counts input cycles and divides by P+1 or P. A 6-bit swallow counter decides how many prescaler periods use P+1, and a 13-bit main counter decides how many prescaler periods make one output period. The reference path is a plain 14-bit divider. Each path emits one single-cycle pulse per completed division.

All logic runs on one system clock. The feedback and reference inputs arrive as clock-enable strobes (`fb_en`, `ref_en`), and only cycles with the strobe high are counted. A synchronous hold input forces both dividers into their load state. On release, both paths start counting on the same edge, so their first pulses are aligned to a common origin. Divider values are captured only at a reload point, so a software write in the middle of a period does not disturb that period.

Top module: `pulse_swallow_div`

## Requirements
- R1: With a valid configuration and every cycle counted, `fb_pulse` is high for one clock after every N-th counted edge since load, where N = B·P + A. This holds at both extremes: A = 0 (all periods divide by P) and A = B (all periods divide by P+1).
- R2: `psel` selects P as follows: 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 64. The prescaler moduli are therefore 8/9, 16/17, 32/33 and 64/65.
- R3: Only clock edges with `fb_en` high advance the feedback path. `fb_pulse` can rise only after an edge that had `fb_en` high.
- R4: `ref_pulse` is high for one clock after every R-th edge with `ref_en` high, for any R from 1 to 16383. With R = 1 it pulses after every counted edge, and a pulse can rise only after an edge with `ref_en` high.
- R5: An R value of 0 is treated as invalid and produces no `ref_pulse`. The reference divider stays in its load state until a nonzero R is presented.
- R6: A configuration with A > B or with B < 3 is invalid and produces no `fb_pulse`. The feedback path stays in its load state and samples `a_val`, `b_val` and `psel` every cycle until they become valid. Counting starts on the edge after they are captured.
- R7: `a_val`, `b_val`, `psel` and `r_val` are captured only at load or reload. A change in the middle of a period leaves that period's length unchanged and applies from the following period.
- R8: While `rst` or `cnt_hold` is high, both pulses are low and both dividers are held at their load state. After release, the first `fb_pulse` follows the N-th counted edge and the first `ref_pulse` follows the R-th counted edge.
- R9: Both outputs are registered. They are low during reset, and `fb_pulse` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_hold | input | 1 | Holds both dividers at their load state while high |
| fb_en | input | 1 | Feedback input strobe; one counted cycle per high sample |
| ref_en | input | 1 | Reference input strobe; one counted cycle per high sample |
| psel | input | 2 | Prescaler select: 0→8, 1→16, 2→32, 3→64 |
| a_val | input | 6 | Swallow count A (0..63) |
| b_val | input | 13 | Main count B (3..8191) |
| r_val | input | 14 | Reference ratio R (1..16383) |
| fb_pulse | output | 1 | One-cycle pulse per N counted feedback cycles |
| ref_pulse | output | 1 | One-cycle pulse per R counted reference cycles |

## Verification
The bench builds the block with its default widths (6-bit A, 13-bit B, 14-bit R, 2-bit prescaler select with a base of 8). Because the widths are the real ones, the largest swallow count (A = 63), a long main count (B = 63, which gives N = 4095) and the full reference range (R = 16383) can all be reached in a short run. The default widths also make it possible to cover every prescaler modulus, from 8/9 to 64/65. The stimulus mixes the A = 0 and A = B extremes, a feedback strobe gated to one cycle in three, invalid A/B and R values followed by recovery, mid-period reprogramming, and a hold in the middle of a run.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  // log2 of the smallest prescaler modulus (8)
  localparam int LOG2_PMIN = 3;
  // smallest legal main count
  localparam int MIN_B = 3;

  typedef enum logic [1:0] {
    PS_DIV8  = 2'd0,
    PS_DIV16 = 2'd1,
    PS_DIV32 = 2'd2,
    PS_DIV64 = 2'd3
  } psel_e;
endpackage

// File: rtl/pdiv_prescaler.sv
module pdiv_prescaler #(
  parameter int PSEL_W = 2,
  parameter int PCNT_W = pdiv_pkg::LOG2_PMIN + (1 << PSEL_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              in_en,
  input  logic [PSEL_W-1:0] p_sel,
  input  logic              swallow,
  output logic              wrap
);
  import pdiv_pkg::*;

  logic [PCNT_W-1:0] pcnt;
  logic [PCNT_W-1:0] base;
  logic [PCNT_W-1:0] last;

  // modulus is P, or P+1 while the swallow counter is still nonzero
  always_comb begin
    base = PCNT_W'(1) << (LOG2_PMIN + int'(p_sel));
    last = base - PCNT_W'(1) + PCNT_W'(swallow);
  end

  assign wrap = run && in_en && (pcnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
    end else if (in_en) begin
      if (pcnt == last) pcnt <= '0;
      else              pcnt <= pcnt + PCNT_W'(1);
    end
  end
endmodule

// File: rtl/pdiv_swallow_ctrl.sv
module pdiv_swallow_ctrl #(
  parameter int A_W    = 6,
  parameter int B_W    = 13,
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [A_W-1:0]    a_in,
  input  logic [B_W-1:0]    b_in,
  input  logic [PSEL_W-1:0] p_in,
  input  logic              pre_wrap,
  output logic [PSEL_W-1:0] p_act,
  output logic              swallow,
  output logic              cfg_ok,
  output logic              pulse
);
  import pdiv_pkg::*;

  logic [A_W-1:0] a_cnt;
  logic [B_W-1:0] b_cnt;
  logic [B_W-1:0] b_act;
  logic           in_ok;

  // legality of the values presented at the inputs
  always_comb begin
    in_ok = (b_in >= B_W'(MIN_B)) && ({{(B_W-A_W){1'b0}}, a_in} <= b_in);
  end

  assign swallow = (a_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst || hold || !cfg_ok) begin
      // load state: sample new values every cycle
      a_cnt  <= a_in;
      b_cnt  <= '0;
      b_act  <= b_in;
      p_act  <= p_in;
      cfg_ok <= in_ok;
      pulse  <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (pre_wrap) begin
        if (b_cnt == b_act - B_W'(1)) begin
          a_cnt  <= a_in;
          b_cnt  <= '0;
          b_act  <= b_in;
          p_act  <= p_in;
          cfg_ok <= in_ok;
          pulse  <= 1'b1;
        end else begin
          b_cnt <= b_cnt + B_W'(1);
          if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pdiv_ref_div.sv
module pdiv_ref_div #(
  parameter int R_W = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  input  logic           in_en,
  input  logic [R_W-1:0] r_in,
  output logic           pulse
);
  logic [R_W-1:0] r_cnt;
  logic [R_W-1:0] r_act;

  always_ff @(posedge clk) begin
    if (rst || hold || (r_act == '0)) begin
      r_cnt <= '0;
      r_act <= r_in;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (in_en) begin
        if (r_cnt == r_act - R_W'(1)) begin
          r_cnt <= '0;
          r_act <= r_in;
          pulse <= 1'b1;
        end else begin
          r_cnt <= r_cnt + R_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int A_W    = 6,
  parameter int B_W    = 13,
  parameter int R_W    = 14,
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_hold,
  input  logic              fb_en,
  input  logic              ref_en,
  input  logic [PSEL_W-1:0] psel,
  input  logic [A_W-1:0]    a_val,
  input  logic [B_W-1:0]    b_val,
  input  logic [R_W-1:0]    r_val,
  output logic              fb_pulse,
  output logic              ref_pulse
);
  localparam int PCNT_W = pdiv_pkg::LOG2_PMIN + (1 << PSEL_W);

  logic              pre_wrap;
  logic              swallow;
  logic              cfg_ok;
  logic              run;
  logic [PSEL_W-1:0] p_act;

  assign run = !cnt_hold && cfg_ok;

  pdiv_prescaler #(.PSEL_W(PSEL_W), .PCNT_W(PCNT_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .in_en   (fb_en),
    .p_sel   (p_act),
    .swallow (swallow),
    .wrap    (pre_wrap)
  );

  pdiv_swallow_ctrl #(.A_W(A_W), .B_W(B_W), .PSEL_W(PSEL_W)) u_ab (
    .clk      (clk),
    .rst      (rst),
    .hold     (cnt_hold),
    .a_in     (a_val),
    .b_in     (b_val),
    .p_in     (psel),
    .pre_wrap (pre_wrap),
    .p_act    (p_act),
    .swallow  (swallow),
    .cfg_ok   (cfg_ok),
    .pulse    (fb_pulse)
  );

  pdiv_ref_div #(.R_W(R_W)) u_ref (
    .clk   (clk),
    .rst   (rst),
    .hold  (cnt_hold),
    .in_en (ref_en),
    .r_in  (r_val),
    .pulse (ref_pulse)
  );
endmodule

// File: rtl/pulse_swallow_div_chk.sv
module pulse_swallow_div_chk (
  input logic clk,
  input logic rst,
  input logic cnt_hold,
  input logic fb_en,
  input logic ref_en,
  input logic fb_pulse,
  input logic ref_pulse
);
  // R9
  fb_single_chk: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse);

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_hold |=> (!fb_pulse && !ref_pulse));

  // R3
  fb_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fb_pulse) |-> $past(fb_en));

  // R4
  ref_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |-> $past(ref_en));
endmodule

bind pulse_swallow_div pulse_swallow_div_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_hold  (cnt_hold),
  .fb_en     (fb_en),
  .ref_en    (ref_en),
  .fb_pulse  (fb_pulse),
  .ref_pulse (ref_pulse)
);

// File: tb/pulse_swallow_div_test.sv
`timescale 1ns/1ps
module pulse_swallow_div_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_hold = 1'b0;
  logic        fb_en = 1'b0;
  logic        ref_en = 1'b0;
  logic [1:0]  psel = 2'd0;
  logic [5:0]  a_val = 6'd0;
  logic [12:0] b_val = 13'd3;
  logic [13:0] r_val = 14'd1;
  logic        fb_pulse;
  logic        ref_pulse;

  always #4 clk = ~clk;

  pulse_swallow_div uut (
    .clk(clk), .rst(rst), .cnt_hold(cnt_hold), .fb_en(fb_en), .ref_en(ref_en),
    .psel(psel), .a_val(a_val), .b_val(b_val), .r_val(r_val),
    .fb_pulse(fb_pulse), .ref_pulse(ref_pulse)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // independent behavioural model
  int fc = 0, n_act = 0, rc = 0, r_act = 0;
  bit nv = 0;
  logic exp_fb = 0, exp_ref = 0;
  int fb_seen = 0, ref_seen = 0;

  // psel, a, b, r
  localparam int NV = 7;
  localparam int VEC [NV][4] = '{
    '{0,  0,  3,  1},
    '{0,  3,  3,  5},
    '{0,  2,  5,  7},
    '{1,  1,  3,  2},
    '{2,  4,  4,  3},
    '{3,  2,  3, 16},
    '{3, 63, 63, 40}
  };

  function automatic int ratio_n(int ps, int a, int b);
    return b * (8 << ps) + a;
  endfunction

  function automatic bit ab_ok(int a, int b);
    return (b >= 3) && (a <= b);
  endfunction

  task automatic check(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", cur_req, what, act, exp);
    end
  endtask

  task automatic model_edge(input logic fbe, input logic rfe);
    exp_fb = 0;
    exp_ref = 0;
    if (rst || cnt_hold) begin
      fc = 0; n_act = ratio_n(psel, a_val, b_val); nv = ab_ok(a_val, b_val);
      rc = 0; r_act = r_val;
    end else begin
      if (!nv) begin
        n_act = ratio_n(psel, a_val, b_val); nv = ab_ok(a_val, b_val);
      end else if (fbe) begin
        fc++;
        if (fc == n_act) begin
          exp_fb = 1; fc = 0;
          n_act = ratio_n(psel, a_val, b_val); nv = ab_ok(a_val, b_val);
        end
      end
      if (r_act == 0) begin
        r_act = r_val;
      end else if (rfe) begin
        rc++;
        if (rc == r_act) begin
          exp_ref = 1; rc = 0; r_act = r_val;
        end
      end
    end
  endtask

  task automatic step(input logic fbe, input logic rfe);
    fb_en = fbe;
    ref_en = rfe;
    @(posedge clk);
    model_edge(fbe, rfe);
    @(negedge clk);
    check(fb_pulse, exp_fb, "fb_pulse");
    check(ref_pulse, exp_ref, "ref_pulse");
    if (fb_pulse) fb_seen++;
    if (ref_pulse) ref_seen++;
  endtask

  task automatic load_cfg(input int ps, input int a, input int b, input int r);
    psel = 2'(ps); a_val = 6'(a); b_val = 13'(b); r_val = 14'(r);
    cnt_hold = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    cnt_hold = 1'b0;
  endtask

  task automatic count_check(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(150000 * 8);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R9: reset state
    cur_req = "R9";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    rst = 1'b0;

    // R1 / R2 / R4: vector table, every cycle counted
    foreach (VEC[v]) begin
      int nn, len;
      cur_req = (v == 0 || v == 1) ? "R1" : (v >= 3 ? "R2" : "R4");
      nn  = ratio_n(VEC[v][0], VEC[v][1], VEC[v][2]);
      len = 2 * ((nn > VEC[v][3]) ? nn : VEC[v][3]) + 4;
      load_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      fb_seen = 0;
      for (int k = 0; k < len; k++) step(1'b1, 1'b1);
      count_check(fb_seen, len / nn, "fb pulse count");
    end

    // R3: feedback strobe high one cycle in three (N = 25)
    cur_req = "R3";
    load_cfg(0, 1, 3, 4);
    fb_seen = 0;
    for (int k = 0; k < 150; k++) step((k % 3) == 0, 1'b1);
    count_check(fb_seen, 2, "gated fb pulses");

    // R4: largest and smallest reference ratio
    cur_req = "R4";
    load_cfg(0, 0, 3, 16383);
    ref_seen = 0;
    for (int k = 0; k < 16390; k++) step(1'b0, 1'b1);
    count_check(ref_seen, 1, "R=16383 pulses");
    load_cfg(0, 0, 3, 1);
    ref_seen = 0;
    for (int k = 0; k < 10; k++) step(1'b0, 1'b1);
    count_check(ref_seen, 10, "R=1 pulses");

    // R5: R = 0 gives nothing, then recovers
    cur_req = "R5";
    load_cfg(0, 0, 3, 0);
    ref_seen = 0;
    for (int k = 0; k < 50; k++) step(1'b1, 1'b1);
    count_check(ref_seen, 0, "R=0 pulses");
    r_val = 14'd6;
    for (int k = 0; k < 20; k++) step(1'b1, 1'b1);

    // R6: A > B, then B < 3, then recovery without hold
    cur_req = "R6";
    load_cfg(0, 5, 4, 3);
    fb_seen = 0;
    for (int k = 0; k < 120; k++) step(1'b1, 1'b1);
    b_val = 13'd2; a_val = 6'd0;
    for (int k = 0; k < 120; k++) step(1'b1, 1'b1);
    count_check(fb_seen, 0, "invalid fb pulses");
    b_val = 13'd3;
    for (int k = 0; k < 60; k++) step(1'b1, 1'b1);
    count_check(fb_seen, 2, "recovered fb pulses");

    // R7: change in mid-period applies from next period (24 then 33)
    cur_req = "R7";
    load_cfg(0, 0, 3, 5);
    for (int k = 0; k < 10; k++) step(1'b1, 1'b1);
    a_val = 6'd1; b_val = 13'd4; r_val = 14'd9;
    for (int k = 0; k < 80; k++) step(1'b1, 1'b1);

    // R8: hold in mid-run realigns both paths
    cur_req = "R8";
    load_cfg(0, 2, 5, 7);
    for (int k = 0; k < 30; k++) step(1'b1, 1'b1);
    cnt_hold = 1'b1;
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1);
    cnt_hold = 1'b0;
    for (int k = 0; k < 90; k++) step(1'b1, 1'b1);

    // R9: reset mid-run clears outputs
    cur_req = "R9";
    rst = 1'b1;
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1);
    rst = 1'b0;
    for (int k = 0; k < 50; k++) step(1'b1, 1'b1);

    finish_run();
  end
endmodule